// File: doc/BRIEF.md
# Boot-time configuration loader from serial EEPROM

This block fills a bank of 64 read-only configuration bytes as soon as the chip leaves reset. When the enable input is high, it reads the contents from an external three-wire serial EEPROM. It drives the chip select, the serial clock and the command line, and it shifts the returned data in from the EEPROM's output pin. When the enable input is low, the same bank is filled in a single cycle with built-in default values.

The block issues 32 separate read frames, one for each 16-bit word, at ascending word addresses. Each frame carries a start bit, a two-bit read opcode and a six-bit address. The EEPROM then returns one dummy bit and sixteen data bits. The serial clock is the system clock divided by a parameter.

When the bank is complete, a done flag rises and stays high until the next reset. Logic that reads the configuration waits for this flag.

Top module: `cfg_rom_loader`

## Requirements
- R1: Whenever `rst_n` is low, `ee_cs`, `ee_sck`, `ee_do` and `load_done` are 0 and every byte of `cfg_bytes` is 0. After reset is released with `ee_enable` high, the first frame starts by itself: `ee_cs` rises within DIV+2 clock cycles.
- R2: With `ee_enable` high, exactly 32 frames are sent, at word addresses 0, 1, …, 31 in that order. The first nine bits of each frame on `ee_do` are 1, 1, 0, followed by the 6-bit address, most significant bit first.
- R3: `ee_cs` is active high and stays high for exactly 26 serial-clock periods per frame. Between frames it stays low for at least DIV clock cycles. `ee_sck` is low whenever `ee_cs` is low.
- R4: `ee_sck` has a period of DIV clock cycles inside a frame. `ee_do` changes only on a falling edge of `ee_sck` or when `ee_cs` changes. The receiver samples on the rising edge.
- R5: The 16 bits sampled on rising edges 11 to 26 of a frame form the data word, most significant bit first. The high byte of word w is stored at byte index 2w and the low byte at 2w+1. Byte i appears on `cfg_bytes[8*i+7:8*i]`.
- R6: `load_done` rises once all 64 bytes are stored and stays high until reset. No frame starts after it rises.
- R7: If `ee_enable` is low in the first cycle after reset, no frame is sent. Byte i is set to 8'hA5 XOR i, and `load_done` is high within 2 cycles.
- R8: `ee_enable` is sampled only in the first cycle after reset. Changing it later changes neither `cfg_bytes` nor the serial pins.
- R9: Asserting reset during a load aborts the load. The next load starts again from word address 0.
- R10: The value on `ee_di` during the command bits and the dummy bit has no effect on the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the load |
| ee_enable | input | 1 | High: load from the EEPROM; low: load the defaults |
| ee_di | input | 1 | Serial data returned by the EEPROM |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Serial command and address to the EEPROM |
| load_done | output | 1 | Configuration bank complete |
| cfg_bytes | output | 512 | The 64 configuration bytes, byte i at bits 8i+7..8i |

## Verification
A behavioural EEPROM serves two word patterns. One pattern gives each word a distinct high and low byte, which exposes swapped bytes or an address offset. The other alternates bit polarity between neighbouring words, which exposes a shift that is off by one bit.

In one run the model drives `ee_di` to 1 outside the data slots. This shows that command and dummy slots are never captured. A run that boots with the enable input low, and a toggle of the enable input after the load, separate the boot-time decision from later input changes. A reset in the middle of a load shows that the word counter restarts at address 0.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    // Word width returned by the EEPROM per frame.
    localparam int WORD_W = 16;
    // Start bit followed by the two-bit read opcode.
    localparam logic [2:0] RD_HEAD = 3'b110;

    typedef enum logic [1:0] {SQ_BOOT, SQ_FETCH, SQ_DONE} seq_e;
    typedef enum logic {FR_IDLE, FR_RUN} frm_e;
endpackage

// File: rtl/cfgld_sck_div.sv
module cfgld_sck_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic fall_o,
    output logic rise_o
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == CW'(DIV - 1)) div_d.cnt = '0;
        else                           div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign fall_o = (div_q.cnt == '0);
    assign rise_o = (div_q.cnt == CW'(HALF));
endmodule

// File: rtl/cfgld_frame.sv
module cfgld_frame
    import cfgld_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              di_i,
    output logic              cs_o,
    output logic              sck_o,
    output logic              do_o,
    output logic              busy_o,
    output logic              vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CMD_W  = 3 + ADDR_W;
    localparam int SLOTS  = CMD_W + 1 + WORD_W;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        frm_e              st;
        logic              cs;
        logic              sck;
        logic              dout;
        logic              vld;
        logic [SLOT_W-1:0] slot;
        logic [CMD_W-1:0]  cmd;
        logic [WORD_W-1:0] data;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d     = fr_q;
        fr_d.vld = 1'b0;
        case (fr_q.st)
            FR_IDLE: begin
                // A frame only opens on a falling-edge strobe, so the
                // select stays low for at least one full serial period.
                if (start_i && fall_i) begin
                    fr_d.st   = FR_RUN;
                    fr_d.cs   = 1'b1;
                    fr_d.slot = '0;
                    fr_d.cmd  = {RD_HEAD, addr_i};
                    fr_d.dout = RD_HEAD[2];
                end
            end
            FR_RUN: begin
                if (rise_i) begin
                    fr_d.sck = 1'b1;
                    if (fr_q.slot >= SLOT_W'(CMD_W + 1))
                        fr_d.data = {fr_q.data[WORD_W-2:0], di_i};
                end else if (fall_i) begin
                    fr_d.sck = 1'b0;
                    if (fr_q.slot == SLOT_W'(SLOTS - 1)) begin
                        fr_d.st   = FR_IDLE;
                        fr_d.cs   = 1'b0;
                        fr_d.dout = 1'b0;
                        fr_d.vld  = 1'b1;
                    end else begin
                        fr_d.slot = fr_q.slot + 1'b1;
                        fr_d.cmd  = {fr_q.cmd[CMD_W-2:0], 1'b0};
                        fr_d.dout = fr_d.cmd[CMD_W-1];
                    end
                end
            end
            default: fr_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign cs_o   = fr_q.cs;
    assign sck_o  = fr_q.sck;
    assign do_o   = fr_q.dout;
    assign busy_o = (fr_q.st != FR_IDLE);
    assign vld_o  = fr_q.vld;
    assign word_o = fr_q.data;
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs
    import cfgld_pkg::*;
#(
    parameter int         N_BYTES = 64,
    parameter logic [7:0] DEF_XOR = 8'hA5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           def_en,
    input  logic                           wr_en,
    input  logic [$clog2(N_BYTES)-2:0]     wr_idx,
    input  logic [WORD_W-1:0]              wr_word,
    output logic [N_BYTES*8-1:0]           bytes_o
);
    typedef logic [N_BYTES-1:0][7:0] bank_t;

    bank_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (def_en) begin
            for (int i = 0; i < N_BYTES; i++)
                rf_d[i] = DEF_XOR ^ 8'(i);
        end else if (wr_en) begin
            rf_d[{wr_idx, 1'b0}] = wr_word[WORD_W-1:8];
            rf_d[{wr_idx, 1'b1}] = wr_word[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign bytes_o = rf_q;
endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
    import cfgld_pkg::*;
#(
    parameter int         DIV     = 4,
    parameter int         ADDR_W  = 6,
    parameter int         N_BYTES = 64,
    parameter logic [7:0] DEF_XOR = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ee_enable,
    input  logic                 ee_di,
    output logic                 ee_cs,
    output logic                 ee_sck,
    output logic                 ee_do,
    output logic                 load_done,
    output logic [N_BYTES*8-1:0] cfg_bytes
);
    localparam int N_WORDS = N_BYTES / 2;
    localparam int WIDX_W  = $clog2(N_WORDS);

    typedef struct packed {
        seq_e              st;
        logic [WIDX_W-1:0] widx;
        logic              done;
    } sq_t;

    sq_t sq_d, sq_q;

    logic              fall_s, rise_s;
    logic              start_s, busy_s, vld_s;
    logic              wr_en_s, def_en_s;
    logic [WORD_W-1:0] word_s;

    cfgld_sck_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_o (fall_s),
        .rise_o (rise_s)
    );

    cfgld_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall_s),
        .rise_i  (rise_s),
        .start_i (start_s),
        .addr_i  (ADDR_W'(sq_q.widx)),
        .di_i    (ee_di),
        .cs_o    (ee_cs),
        .sck_o   (ee_sck),
        .do_o    (ee_do),
        .busy_o  (busy_s),
        .vld_o   (vld_s),
        .word_o  (word_s)
    );

    cfgld_regs #(.N_BYTES(N_BYTES), .DEF_XOR(DEF_XOR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .def_en  (def_en_s),
        .wr_en   (wr_en_s),
        .wr_idx  (sq_q.widx),
        .wr_word (word_s),
        .bytes_o (cfg_bytes)
    );

    always_comb begin
        sq_d     = sq_q;
        start_s  = 1'b0;
        wr_en_s  = 1'b0;
        def_en_s = 1'b0;
        case (sq_q.st)
            SQ_BOOT: begin
                // The enable pin is looked at only here, once per reset.
                if (ee_enable) begin
                    sq_d.st = SQ_FETCH;
                end else begin
                    def_en_s  = 1'b1;
                    sq_d.st   = SQ_DONE;
                    sq_d.done = 1'b1;
                end
            end
            SQ_FETCH: begin
                start_s = !busy_s && !vld_s;
                if (vld_s) begin
                    wr_en_s = 1'b1;
                    if (sq_q.widx == WIDX_W'(N_WORDS - 1)) begin
                        sq_d.st   = SQ_DONE;
                        sq_d.done = 1'b1;
                    end else begin
                        sq_d.widx = sq_q.widx + 1'b1;
                    end
                end
            end
            default: sq_d.st = SQ_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SQ_BOOT, widx: '0, done: 1'b0};
        else        sq_q <= sq_d;
    end

    assign load_done = sq_q.done;
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk (
    input logic clk,
    input logic rst_n,
    input logic ee_cs,
    input logic ee_sck,
    input logic ee_do,
    input logic load_done
);
    // R3: the serial clock rests low outside a frame
    a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sck);

    // R3: every rising serial-clock edge lies inside a frame
    a_r3_rise_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sck) |-> ee_cs);

    // R4: command line moves only on a falling clock or a select change
    a_r4_do_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_do) |-> ($fell(ee_sck) || !$stable(ee_cs)));

    // R6: done holds until reset
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // R6: no frame once done
    a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !ee_cs);
endmodule

bind cfg_rom_loader cfgld_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ee_cs     (ee_cs),
    .ee_sck    (ee_sck),
    .ee_do     (ee_do),
    .load_done (load_done)
);

// File: tb/sim_cfg_rom_loader.sv
`timescale 1ns/1ps
module sim_cfg_rom_loader;
    localparam int DIV = 4;
    localparam int NB  = 64;

    logic clk = 1'b0, rst_n = 1'b0, ee_enable = 1'b1, ee_di = 1'b0;
    logic ee_cs, ee_sck, ee_do, load_done;
    logic [NB*8-1:0] cfg_bytes;

    cfg_rom_loader #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ee_enable(ee_enable), .ee_di(ee_di),
        .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_do(ee_do),
        .load_done(load_done), .cfg_bytes(cfg_bytes)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int pat = 0;
    bit noise = 1'b0, mon_clr = 1'b1;
    int frames, bad_frames, exp_addr, rises, gap_min, gap_run;
    int per_min, per_max, last_rise, cs_rises, first_cs_cyc, rel_cyc;
    logic [8:0]  cmd;
    logic [15:0] cur_word;
    logic p_cs, p_sck;

    function automatic logic [15:0] mem_word(int p, int a);
        logic [7:0] b;
        b = 8'(a * 4 + 1);
        if (p == 0) return {b, ~b};
        return ((a % 2) ? 16'h55AA : 16'hA55A) ^ 16'(a);
    endfunction

    // EEPROM model and pin monitor, evaluated away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            frames = 0; bad_frames = 0; exp_addr = 0; rises = 0;
            gap_min = 1000; gap_run = 0; per_min = 1000; per_max = 0;
            last_rise = -1; cs_rises = 0; first_cs_cyc = -1;
            cmd = '0; cur_word = '0; p_cs = 1'b0; p_sck = 1'b0;
            ee_di = noise;
        end else begin
            if (ee_cs && !p_cs) begin
                rises = 0; cmd = '0; cs_rises++; last_rise = -1;
                if (cs_rises == 1) first_cs_cyc = cyc;
                if (frames > 0 && gap_run < gap_min) gap_min = gap_run;
            end
            if (!ee_cs && p_cs) begin
                frames++;
                if (rises != 26) bad_frames++;
                gap_run = 0;
                ee_di = noise;
            end
            if (!ee_cs) gap_run++;
            if (ee_cs && ee_sck && !p_sck) begin
                if (rises < 9) cmd = {cmd[7:0], ee_do};
                if (last_rise >= 0) begin
                    if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                    if (cyc - last_rise > per_max) per_max = cyc - last_rise;
                end
                last_rise = cyc;
                rises++;
            end
            if (ee_cs && !ee_sck && p_sck) begin
                if (rises == 9) begin
                    if (cmd != {3'b110, 6'(exp_addr)}) bad_frames++;
                    cur_word = mem_word(pat, exp_addr);
                    exp_addr++;
                    ee_di = noise;
                end else if (rises >= 10 && rises < 26) begin
                    ee_di = cur_word[15 - (rises - 10)];
                end
            end
            p_cs = ee_cs; p_sck = ee_sck;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, act cyc=%0d exp < 150000", cyc);
        summary();
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int byte_errs_eeprom(int p);
        int e = 0;
        for (int i = 0; i < NB; i++) begin
            logic [15:0] w;
            w = mem_word(p, i / 2);
            if (cfg_bytes[i*8 +: 8] != ((i % 2 == 0) ? w[15:8] : w[7:0])) e++;
        end
        return e;
    endfunction

    function automatic int byte_errs_default();
        int e = 0;
        for (int i = 0; i < NB; i++)
            if (cfg_bytes[i*8 +: 8] != (8'hA5 ^ 8'(i))) e++;
        return e;
    endfunction

    task automatic boot(bit en, int p, bit nz);
        rst_n = 1'b0; ee_enable = en; pat = p; noise = nz; mon_clr = 1'b1;
        tick(3);
        mon_clr = 1'b0; rst_n = 1'b1; rel_cyc = cyc;
    endtask

    task automatic wait_done(int limit);
        for (int k = 0; k < limit && !load_done; k++) tick(1);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; mon_clr = 1'b1;
        tick(4);
        chk({ee_cs, ee_sck, ee_do, load_done} == 4'b0, "R1", "pins in reset",
            {ee_cs, ee_sck, ee_do, load_done}, 0);
        chk(cfg_bytes == '0, "R1", "bytes in reset", cfg_bytes[63:0], 0);
    endtask

    task automatic t_eeprom(int p, bit nz, string tag);
        boot(1'b1, p, nz);
        wait_done(20000);
        chk(load_done, "R6", {tag, " done"}, load_done, 1);
        chk(first_cs_cyc - rel_cyc <= DIV + 2, "R1", {tag, " auto start"},
            first_cs_cyc - rel_cyc, DIV + 2);
        chk(frames == 32, "R2", {tag, " frame count"}, frames, 32);
        chk(bad_frames == 0, "R2", {tag, " command/length errors"}, bad_frames, 0);
        chk(gap_min >= DIV, "R3", {tag, " min select gap"}, gap_min, DIV);
        chk(per_min == DIV && per_max == DIV, "R4", {tag, " sck period"},
            per_max * 256 + per_min, DIV * 256 + DIV);
        chk(byte_errs_eeprom(p) == 0,
            nz ? "R10" : "R5", {tag, " byte mismatches"}, byte_errs_eeprom(p), 0);
        tick(300);
        chk(cs_rises == 32, "R6", {tag, " no frame after done"}, cs_rises, 32);
    endtask

    task automatic t_defaults();
        boot(1'b0, 0, 1'b0);
        tick(2);
        chk(load_done, "R7", "done within 2 cycles", load_done, 1);
        chk(byte_errs_default() == 0, "R7", "default bytes", byte_errs_default(), 0);
        ee_enable = 1'b1;
        tick(300);
        chk(cs_rises == 0, "R7", "no frame on default boot", cs_rises, 0);
        chk(byte_errs_default() == 0, "R8", "late enable ignored", byte_errs_default(), 0);
    endtask

    task automatic t_enable_late();
        logic [NB*8-1:0] snap;
        snap = cfg_bytes;
        ee_enable = 1'b0;
        tick(300);
        chk(cfg_bytes == snap, "R8", "bytes after enable drop", cfg_bytes[63:0], snap[63:0]);
        chk(cs_rises == 32 && !ee_cs, "R8", "pins quiet after enable drop", cs_rises, 32);
    endtask

    task automatic t_abort();
        boot(1'b1, 0, 1'b0);
        for (int k = 0; k < 5000 && frames < 5; k++) tick(1);
        chk(frames >= 5 && !load_done, "R9", "mid-load reached", frames, 5);
        rst_n = 1'b0;
        tick(1);
        chk({ee_cs, ee_sck, ee_do, load_done} == 4'b0 && cfg_bytes == '0, "R1",
            "reset during load clears", {ee_cs, ee_sck, ee_do, load_done}, 0);
        t_eeprom(1, 1'b0, "R9 restart");
    endtask

    initial begin
        t_reset_state();
        t_defaults();
        t_eeprom(0, 1'b0, "pattern0");
        t_enable_late();
        t_eeprom(1, 1'b1, "pattern1 noisy");
        t_abort();
        summary();
    end
endmodule